// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes 16-bit cyclic redundancy checks one bit at a time for a synchronous serial channel. A transmit generator folds each outgoing data bit into a shift register. When the send strobe arrives, it shifts out the 16 check bits. A receive checker folds in every incoming bit, including the received check field. At the end-of-frame strobe it gives a pass or fail verdict.

Both sides share one set of configuration inputs:
- a framing kind: idle, plain synchronous or SDLC;
- a polynomial select;
- a preset select.

Each side captures the configuration at its own start-of-frame strobe. In SDLC framing the transmitted check field is inverted. The receiver then expects a fixed nonzero residue instead of zero. When the framing kind is idle, both CRC engines do nothing.

The surrounding channel owns flag detection, bit stuffing and serialisation of the data bits. This block only sees a valid-qualified bit stream with its frame strobes.

Top module: `serial_crc_unit`

## Requirements
- R1: After reset, the latched configuration of both sides is plain synchronous, CRC-16, preset to zeros, and all outputs are low. A send strobe with no prior start-of-frame therefore shifts out sixteen 0 bits. An end-of-frame with no prior start-of-frame reports a pass.
- R2: At a start-of-frame strobe in a non-idle mode, the register is loaded with all ones when `preset_ones_i` is 1 and with all zeros when it is 0. Both choices work with both polynomials. A data bit arriving in the same cycle as start-of-frame is dropped.
- R3: Each data bit `d` updates the register `r` as follows: `fb = r[15] ^ d`, then `r = (r << 1) ^ (fb ? P : 0)`. P is 0x8005 (CRC-16) when `poly_sel_i` is 0 and 0x1021 (CRC-CCITT) when it is 1. Bit 0 of a test word is sent first.
- R4: After a send strobe, each `tx_bit_valid_i` pulse emits one check bit on `tx_out_bit_o`, with `tx_out_valid_o` high one cycle after the enable. Bits are emitted from register bit 15 down to bit 0.
- R5: `tx_crc_done_o` pulses together with the 16th check bit.
- R6: In SDLC mode every transmitted check bit is inverted. In plain synchronous mode check bits are sent as held.
- R7: In plain synchronous mode, a frame passes (`rx_crc_err_o` = 0) exactly when the register is zero after the data and check bits.
- R8: In SDLC mode, a frame passes exactly when the register equals the residue left by an inverted check field. That residue is 0x1D0F for CRC-CCITT and (0xFFFF·x^16) mod P for CRC-16.
- R9: `rx_err_valid_o` pulses one cycle after `rx_eof_i`. `rx_crc_err_o` changes only in that cycle and holds until the next verdict. A bit that arrives in the same cycle as end-of-frame is included in the check.
- R10: In idle mode, send strobes and bit enables produce no transmit output. End-of-frame produces no verdict and leaves `rx_crc_err_o` unchanged.
- R11: A send strobe during the check-bit shift is ignored. After the done pulse, further bit enables emit nothing until the next send strobe.
- R12: Any single-bit error in the data or check field of a received frame raises `rx_crc_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Framing kind: 00 idle, 01 plain synchronous, 10 or 11 SDLC |
| poly_sel_i | input | 1 | 0 selects CRC-16, 1 selects CRC-CCITT |
| preset_ones_i | input | 1 | 1 presets the register to all ones, 0 to all zeros |
| tx_sof_i | input | 1 | Transmit start-of-frame strobe; latches configuration and preset |
| tx_bit_valid_i | input | 1 | Transmit bit enable |
| tx_bit_i | input | 1 | Transmit data bit |
| tx_send_crc_i | input | 1 | Starts shifting out the 16 check bits |
| tx_out_valid_o | output | 1 | A check bit is on `tx_out_bit_o` |
| tx_out_bit_o | output | 1 | Check bit output |
| tx_crc_done_o | output | 1 | Pulses with the last check bit |
| rx_sof_i | input | 1 | Receive start-of-frame strobe |
| rx_bit_valid_i | input | 1 | Receive bit enable |
| rx_bit_i | input | 1 | Received bit (data or check field) |
| rx_eof_i | input | 1 | Receive end-of-frame strobe |
| rx_err_valid_o | output | 1 | Verdict pulse |
| rx_crc_err_o | output | 1 | Held verdict: 1 means CRC mismatch |

## Verification
The in-line assertions watch the cycle-level framing on every cycle:
- the done pulse coincides with an emitted bit, and no bit follows it;
- emitted bits follow an enable;
- the verdict follows end-of-frame;
- the verdict holds between pulses;
- nothing leaves either side in idle mode.

Whether the check bits and verdicts are numerically right cannot be seen as a per-cycle property, so the bench's scenarios establish it. The bench sweeps both polynomials, both presets and both framing kinds over several data patterns. It compares the emitted bits with an arithmetic model, loops them back into the checker, and flips single bits to confirm that errors are caught.

// File: rtl/crc_pkg.sv
// Shared constants, configuration types and the one-bit CRC update.
// Assumes a 16-bit register, with each data bit XORed into the top bit.
package crc_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] POLY_CRC16 = 16'h8005;
    localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;

    typedef enum logic [1:0] {
        FRAME_OFF  = 2'b00,
        FRAME_SYNC = 2'b01,
        FRAME_SDLC = 2'b10
    } frame_kind_t;

    typedef struct packed {
        frame_kind_t kind;
        logic        poly_b;
        logic        ones;
    } crc_cfg_t;

    localparam crc_cfg_t CFG_RESET = '{kind: FRAME_SYNC, poly_b: 1'b0, ones: 1'b0};

    // Map the two-bit mode pins onto a framing kind.
    function automatic frame_kind_t decode_kind(input logic [1:0] m);
        case (m)
            2'b00:   return FRAME_OFF;
            2'b01:   return FRAME_SYNC;
            default: return FRAME_SDLC;
        endcase
    endfunction

    // Choose the generator polynomial.
    function automatic logic [CRC_W-1:0] poly_of(input logic b);
        return b ? POLY_CCITT : POLY_CRC16;
    endfunction

    // Fold one bit into the register.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                  input logic d, input logic b);
        logic fb;
        fb = r[CRC_W-1] ^ d;
        return (r << 1) ^ (fb ? poly_of(b) : '0);
    endfunction

    // Residue that an inverted check field leaves: sixteen ones fed from zero.
    function automatic logic [CRC_W-1:0] sdlc_residue(input logic b);
        logic [CRC_W-1:0] r;
        r = '0;
        for (int i = 0; i < CRC_W; i++) r = crc_step(r, 1'b1, b);
        return r;
    endfunction

endpackage

// File: rtl/crc_tx_gen.sv
// Transmit CRC generator. Accumulates data bits, then on a send strobe shifts
// out the register from the top bit down, one bit per enable.
// Assumes data bits arrive only after start-of-frame and before the send strobe.
module crc_tx_gen
    import crc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sof_i,
    input  crc_cfg_t cfg_i,
    input  logic     bit_valid_i,
    input  logic     bit_i,
    input  logic     send_i,
    output logic     out_valid_o,
    output logic     out_bit_o,
    output logic     done_o
);
    localparam int CNT_W = $clog2(CRC_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CRC_W - 1);

    crc_cfg_t         cfg_q;
    logic [CRC_W-1:0] crc_q;
    logic             sending_q;
    logic [CNT_W-1:0] cnt_q;

    // Frame start, accumulation and check-bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= CFG_RESET;
            crc_q       <= '0;
            sending_q   <= 1'b0;
            cnt_q       <= '0;
            out_valid_o <= 1'b0;
            out_bit_o   <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            out_valid_o <= 1'b0;
            done_o      <= 1'b0;
            if (sof_i) begin
                cfg_q     <= cfg_i;
                sending_q <= 1'b0;
                cnt_q     <= '0;
                if (cfg_i.kind != FRAME_OFF) crc_q <= {CRC_W{cfg_i.ones}};
            end else if (cfg_q.kind == FRAME_OFF) begin
                crc_q <= crc_q;
            end else if (sending_q) begin
                if (bit_valid_i) begin
                    out_valid_o <= 1'b1;
                    out_bit_o   <= crc_q[CRC_W-1] ^ (cfg_q.kind == FRAME_SDLC);
                    crc_q       <= crc_q << 1;
                    cnt_q       <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        done_o    <= 1'b1;
                        sending_q <= 1'b0;
                        cnt_q     <= '0;
                    end
                end
            end else if (send_i) begin
                sending_q <= 1'b1;
                cnt_q     <= '0;
            end else if (bit_valid_i) begin
                crc_q <= crc_step(crc_q, bit_i, cfg_q.poly_b);
            end
        end
    end

    assert_done_with_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> out_valid_o);
    assert_bit_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(bit_valid_i));
    assert_silent_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !out_valid_o);
    assert_off_no_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.kind == FRAME_OFF) |=> !out_valid_o);
endmodule

// File: rtl/crc_rx_chk.sv
// Receive CRC checker. Accumulates data and check bits, and on end-of-frame
// compares the register with zero or with the SDLC residue.
// Assumes the check field arrives top bit first, as the generator emits it.
module crc_rx_chk
    import crc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sof_i,
    input  crc_cfg_t cfg_i,
    input  logic     bit_valid_i,
    input  logic     bit_i,
    input  logic     eof_i,
    output logic     err_valid_o,
    output logic     err_o
);
    crc_cfg_t         cfg_q;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;
    logic [CRC_W-1:0] expect_val;

    // Register value including any bit of this cycle, and the pass value.
    always_comb begin
        crc_nxt    = bit_valid_i ? crc_step(crc_q, bit_i, cfg_q.poly_b) : crc_q;
        expect_val = (cfg_q.kind == FRAME_SDLC) ? sdlc_residue(cfg_q.poly_b) : '0;
    end

    // Frame start, accumulation and verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= CFG_RESET;
            crc_q       <= '0;
            err_valid_o <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            err_valid_o <= 1'b0;
            if (sof_i) begin
                cfg_q <= cfg_i;
                if (cfg_i.kind != FRAME_OFF) crc_q <= {CRC_W{cfg_i.ones}};
            end else if (cfg_q.kind != FRAME_OFF) begin
                crc_q <= crc_nxt;
                if (eof_i) begin
                    err_valid_o <= 1'b1;
                    err_o       <= (crc_nxt != expect_val);
                end
            end
        end
    end

    assert_verdict_after_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_i && !sof_i && cfg_q.kind != FRAME_OFF) |=> err_valid_o);
    assert_verdict_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid_o |-> $stable(err_o));
    assert_off_no_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.kind == FRAME_OFF) |=> !err_valid_o);
endmodule

// File: rtl/serial_crc_unit.sv
// Top of the serial CRC unit: decodes the shared configuration pins and
// feeds them to the transmit generator and the receive checker.
// Assumes configuration pins are steady at each side's start-of-frame.
module serial_crc_unit
    import crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       poly_sel_i,
    input  logic       preset_ones_i,
    input  logic       tx_sof_i,
    input  logic       tx_bit_valid_i,
    input  logic       tx_bit_i,
    input  logic       tx_send_crc_i,
    output logic       tx_out_valid_o,
    output logic       tx_out_bit_o,
    output logic       tx_crc_done_o,
    input  logic       rx_sof_i,
    input  logic       rx_bit_valid_i,
    input  logic       rx_bit_i,
    input  logic       rx_eof_i,
    output logic       rx_err_valid_o,
    output logic       rx_crc_err_o
);
    crc_cfg_t cfg_w;

    // Pack the configuration pins into one record.
    always_comb begin
        cfg_w.kind   = decode_kind(mode_i);
        cfg_w.poly_b = poly_sel_i;
        cfg_w.ones   = preset_ones_i;
    end

    crc_tx_gen u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (tx_sof_i),
        .cfg_i       (cfg_w),
        .bit_valid_i (tx_bit_valid_i),
        .bit_i       (tx_bit_i),
        .send_i      (tx_send_crc_i),
        .out_valid_o (tx_out_valid_o),
        .out_bit_o   (tx_out_bit_o),
        .done_o      (tx_crc_done_o)
    );

    crc_rx_chk u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (rx_sof_i),
        .cfg_i       (cfg_w),
        .bit_valid_i (rx_bit_valid_i),
        .bit_i       (rx_bit_i),
        .eof_i       (rx_eof_i),
        .err_valid_o (rx_err_valid_o),
        .err_o       (rx_crc_err_o)
    );
endmodule

// File: tb/tb_serial_crc_unit.sv
// Sweeps framing kind, polynomial, preset and data patterns; checks emitted
// check bits against an arithmetic model and loops them back into the checker.
module tb_serial_crc_unit;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic       rst_n;
    logic [1:0] mode;
    logic       poly_sel, preset_ones;
    logic       tx_sof, tx_bit_valid, tx_bit, tx_send;
    logic       tx_out_valid, tx_out_bit, tx_done;
    logic       rx_sof, rx_bit_valid, rx_bit, rx_eof;
    logic       rx_err_valid, rx_err;

    int n_checks = 0;
    int n_err = 0;

    serial_crc_unit dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .poly_sel_i(poly_sel),
        .preset_ones_i(preset_ones), .tx_sof_i(tx_sof), .tx_bit_valid_i(tx_bit_valid),
        .tx_bit_i(tx_bit), .tx_send_crc_i(tx_send), .tx_out_valid_o(tx_out_valid),
        .tx_out_bit_o(tx_out_bit), .tx_crc_done_o(tx_done), .rx_sof_i(rx_sof),
        .rx_bit_valid_i(rx_bit_valid), .rx_bit_i(rx_bit), .rx_eof_i(rx_eof),
        .rx_err_valid_o(rx_err_valid), .rx_crc_err_o(rx_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference CRC as polynomial arithmetic over the data bits.
    function automatic logic [15:0] model_crc(input logic pb, input logic ones,
                                              input logic [63:0] d, input int n);
        logic [16:0] v;
        logic [16:0] g;
        g = pb ? 17'h11021 : 17'h18005;
        v = {1'b0, {16{ones}}};
        for (int i = 0; i < n; i++) begin
            v = {v[15:0], 1'b0} ^ {d[i], 16'h0};
            if (v[16]) v = v ^ g;
        end
        return v[15:0];
    endfunction

    // Residue of an inverted check field: (0xFFFF * x^16) mod P.
    function automatic logic [15:0] model_residue(input logic pb);
        logic [31:0] v;
        if (pb) return 16'h1D0F;
        v = 32'hFFFF_0000;
        for (int b = 31; b >= 16; b--)
            if (v[b]) v = v ^ (32'h0001_8005 << (b - 16));
        return v[15:0];
    endfunction

    task automatic tx_frame(input bit do_sof, input logic [63:0] d, input int n,
                            input bit extra_send, output logic [15:0] got,
                            output bit valid_ok, output bit done_ok, output bit quiet_ok);
        if (do_sof) begin
            @(negedge clk) tx_sof = 1'b1;
            @(negedge clk) tx_sof = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            tx_bit_valid = 1'b1; tx_bit = d[i];
            @(negedge clk);
            tx_bit_valid = 1'b0;
        end
        tx_send = 1'b1;
        @(negedge clk) tx_send = 1'b0;
        got = '0; valid_ok = 1'b1; done_ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            tx_bit_valid = 1'b1; tx_bit = 1'b0;
            tx_send = extra_send && (i == 5);
            @(negedge clk);
            tx_bit_valid = 1'b0; tx_send = 1'b0;
            if (!tx_out_valid) valid_ok = 1'b0;
            got = {got[14:0], tx_out_bit};
            if (tx_done != (i == 15)) done_ok = 1'b0;
        end
        tx_bit_valid = 1'b1;
        @(negedge clk);
        tx_bit_valid = 1'b0;
        quiet_ok = !tx_out_valid;
    endtask

    task automatic rx_frame(input logic [63:0] d, input int n, input logic [15:0] crc,
                            input int flip, input bit eof_last,
                            output logic errv, output logic err);
        int total;
        logic b;
        total = n + 16;
        @(negedge clk) rx_sof = 1'b1;
        @(negedge clk) rx_sof = 1'b0;
        for (int i = 0; i < total; i++) begin
            b = (i < n) ? d[i] : crc[15 - (i - n)];
            if (i == flip) b = ~b;
            rx_bit_valid = 1'b1; rx_bit = b;
            rx_eof = eof_last && (i == total - 1);
            @(negedge clk);
            rx_bit_valid = 1'b0; rx_eof = 1'b0;
        end
        if (!eof_last) begin
            rx_eof = 1'b1;
            @(negedge clk) rx_eof = 1'b0;
        end
        errv = rx_err_valid;
        err  = rx_err;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_checks++; n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] pats [3];
        int          lens [3];
        logic [15:0] got, exp_w;
        bit          vok, dok, qok;
        logic        ev, er;
        pats[0] = 64'hA5C3_0F17_9E2D_4B86; lens[0] = 8;
        pats[1] = 64'h0000_0000_0000_F00D; lens[1] = 16;
        pats[2] = 64'h1234_5678_DEAD_BEEF; lens[2] = 33;

        rst_n = 1'b0; mode = 2'b01; poly_sel = 1'b1; preset_ones = 1'b1;
        tx_sof = 0; tx_bit_valid = 0; tx_bit = 0; tx_send = 0;
        rx_sof = 0; rx_bit_valid = 0; rx_bit = 0; rx_eof = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({tx_out_valid, tx_done, rx_err_valid, rx_err} == 4'b0, "R1 outputs low after reset",
            {tx_out_valid, tx_done, rx_err_valid, rx_err}, 0);

        // R1: reset configuration preset zeros, no sof -> sixteen zero bits.
        tx_frame(1'b0, 64'h0, 0, 1'b0, got, vok, dok, qok);
        chk(got == 16'h0000, "R1 send without sof", got, 16'h0000);
        @(negedge clk) rx_eof = 1'b1;
        @(negedge clk) rx_eof = 1'b0;
        chk(rx_err_valid && !rx_err, "R1 eof without sof passes", {rx_err_valid, rx_err}, 2'b10);

        // Sweep: framing kind x polynomial x preset x pattern.
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 2; p++)
                for (int o = 0; o < 2; o++)
                    for (int k = 0; k < 3; k++) begin
                        mode = (m == 1) ? 2'b10 : 2'b01;
                        poly_sel = p[0]; preset_ones = o[0];
                        exp_w = model_crc(p[0], o[0], pats[k], lens[k]) ^ ((m == 1) ? 16'hFFFF : 16'h0);
                        tx_frame(1'b1, pats[k], lens[k], k == 1, got, vok, dok, qok);
                        chk(got == exp_w, "R2 R3 R6 check bits", got, exp_w);
                        chk(vok, "R4 valid on each enable", vok, 1);
                        chk(dok, "R5 done with 16th bit", dok, 1);
                        chk(qok, "R11 silent after done", qok, 1);
                        rx_frame(pats[k], lens[k], got, -1, 1'b0, ev, er);
                        chk(ev && !er, (m == 1) ? "R8 SDLC good frame" : "R7 sync good frame",
                            {ev, er}, 2'b10);
                        rx_frame(pats[k], lens[k], got, (k * 7 + p * 5 + o * 3 + 3) % (lens[k] + 16),
                                 1'b0, ev, er);
                        chk(ev && er, "R12 single-bit error flagged", {ev, er}, 2'b11);
                    end

        // R8: direct residue check, CRC-16 SDLC frame with raw (uninverted) field fails.
        mode = 2'b10; poly_sel = 1'b0; preset_ones = 1'b1;
        exp_w = model_crc(1'b0, 1'b1, pats[0], lens[0]);
        rx_frame(pats[0], lens[0], exp_w, -1, 1'b0, ev, er);
        chk(ev && (er == (model_residue(1'b0) != 16'h0)), "R8 uninverted field in SDLC",
            {ev, er}, {1'b1, model_residue(1'b0) != 16'h0});

        // R9: last bit arriving with end-of-frame.
        mode = 2'b10; poly_sel = 1'b1; preset_ones = 1'b1;
        exp_w = model_crc(1'b1, 1'b1, pats[2], lens[2]) ^ 16'hFFFF;
        rx_frame(pats[2], lens[2], exp_w, -1, 1'b1, ev, er);
        chk(ev && !er, "R9 eof with last bit passes", {ev, er}, 2'b10);
        rx_frame(pats[2], lens[2], exp_w, lens[2] + 15, 1'b1, ev, er);
        chk(ev && er, "R9 eof with last bit, flipped", {ev, er}, 2'b11);
        @(negedge clk);
        chk(!rx_err_valid && rx_err, "R9 verdict held", {rx_err_valid, rx_err}, 2'b01);

        // R10: idle mode - no transmit output, no verdict, held error stays.
        mode = 2'b00;
        tx_frame(1'b1, pats[0], lens[0], 1'b0, got, vok, dok, qok);
        chk(!vok && qok, "R10 no transmit output when idle", {vok, qok}, 2'b01);
        rx_frame(pats[0], lens[0], 16'h0, -1, 1'b0, ev, er);
        chk(!ev && er, "R10 no verdict when idle", {ev, er}, 2'b01);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule